// File: doc/BRIEF.md
# FIR Tap Sequencer

This block runs a single FIR filter instruction by stepping a multiply-accumulate unit through every tap of the filter. When it accepts an instruction word, it spends one cycle on decode. In that cycle it names the two source registers it needs and clears the accumulator. After decode it issues one data/coefficient read pair in each cycle. The data and coefficient reads go to separate memories, so both can happen in the same cycle.

The data address walks backwards through a circular window. The bounds of that window come from a register. The coefficient address walks forwards from its own base. When the coefficients are symmetric, only half of them are stored, and the coefficient address folds back once it passes the midpoint. After the last tap the block waits a fixed number of cycles for memory latency and pipeline drain. It then raises `done` for one cycle. The host holds the instruction on `instr` while it pulses `start`. The host returns the two register values combinationally from `ra_sel` and `rb_sel`.

Top module: `fir_tap_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `mac_clr`, `rd_en` and `done` are low until an instruction is accepted.
- R2: `start` is accepted only when the block is idle and `instr[23:18]` equals the filter opcode (default 6'h15). It is ignored at any other time, including while busy, in the `done` cycle, and when the opcode is wrong.
- R3: The instruction fields, from the most significant bit, are: opcode [23:18], first register [17:14], second register [13:10], filter symmetry [9:8], coefficient symmetry [7] and order [6:0]. In the cycle after acceptance, `mac_clr` is high for exactly one cycle, and `ra_sel`/`rb_sel` carry the two register fields.
- R4: The first register holds the data start address in [23:12] and the coefficient base in [11:0]. The second register holds the window's upper bound in [23:12] and its lower bound in [11:0]. Both registers are sampled at the end of the decode cycle.
- R5: `rd_en` is high for exactly order+1 consecutive cycles, starting right after decode. `tap_idx` counts 0 up to the order.
- R6: The first data address is the start address. Each later one is the previous address minus one, except that the lower bound is followed by the upper bound.
- R7: With coefficient symmetry 0, the coefficient address is the base plus `tap_idx`, modulo 4096, and `coef_mirror` is low.
- R8: With coefficient symmetry 1, let H = ceil((order+1)/2). Taps below H use base+`tap_idx`. Taps at or above H use base+(order−`tap_idx`) and raise `coef_mirror`.
- R9: During taps, `dual_en` is high when the filter symmetry field is nonzero. `dual_neg` is high when field bit 1 is set and `tap_idx` is odd.
- R10: `busy` stays high for exactly order+7 consecutive cycles. The last of these cycles is the only one with `done` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to execute `instr` |
| instr | input | 24 | Filter instruction word |
| busy | output | 1 | Instruction in progress |
| ra_sel | output | 4 | First register index (valid in decode cycle) |
| rb_sel | output | 4 | Second register index (valid in decode cycle) |
| ra_val | input | 24 | Value of register `ra_sel` |
| rb_val | input | 24 | Value of register `rb_sel` |
| mac_clr | output | 1 | Accumulator clear pulse |
| rd_en | output | 1 | Tap read pair valid |
| dat_addr | output | 12 | Data memory read address |
| cof_addr | output | 12 | Coefficient memory read address |
| tap_idx | output | 7 | Current tap number |
| coef_mirror | output | 1 | Coefficient address is in the folded half |
| dual_en | output | 1 | Produce the dual filter output as well |
| dual_neg | output | 1 | Negate this tap for the dual output |
| done | output | 1 | Last cycle of the instruction |

## Verification
The bench aims at the window edges. It uses a start address equal to the lower bound, a window of a single address, and a window spanning the whole address space. A walker that wraps at the wrong bound, or one cycle late, shows a wrong address on the next tap. It folds coefficients with odd, even and single-tap lengths; an off-by-one midpoint would repeat or skip the centre coefficient. It also sends `start` in the `done` cycle, during the taps, and with a foreign opcode. A design that took any of these would raise `mac_clr` and restart the taps. Both the smallest and the largest order are run, so a tap counter of the wrong length shows as a wrong busy time.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int ORD_W = 7;
  localparam int REG_W = 4;
  localparam int OPC_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_TAP,
    ST_DRAIN,
    ST_DONE
  } fts_state_e;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
    logic [1:0]       fsym;
    logic             csym;
    logic [ORD_W-1:0] ord;
  } fts_instr_t;
endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPC_FILTER = 6'h15,
  parameter int DRAIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  fts_instr_t       instr,
  output logic             busy,
  output logic             in_dec,
  output logic             in_tap,
  output logic             done,
  output logic [ORD_W-1:0] tap_idx,
  output logic [ORD_W-1:0] last_idx,
  output logic [REG_W-1:0] ra_sel,
  output logic [REG_W-1:0] rb_sel,
  output logic [1:0]       fsym,
  output logic             csym
);
  localparam int DRN_W = $clog2(DRAIN_CYC) + 1;
  localparam logic [DRN_W-1:0] DRN_LAST = DRN_W'(DRAIN_CYC - 1);

  fts_state_e       state_q, state_d;
  logic [ORD_W-1:0] cnt_q, cnt_d;
  logic [DRN_W-1:0] drn_q, drn_d;
  fts_instr_t       ins_q;
  logic             ld_ins;
  logic             accept;

  assign accept = start && (instr.opc == OPC_FILTER);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    drn_d   = drn_q;
    ld_ins  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_DEC;
          ld_ins  = 1'b1;
        end
      end
      ST_DEC: begin
        state_d = ST_TAP;
        cnt_d   = '0;
      end
      ST_TAP: begin
        if (cnt_q == ins_q.ord) begin
          state_d = ST_DRAIN;
          drn_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        if (drn_q == DRN_LAST) state_d = ST_DONE;
        else                   drn_d   = drn_q + 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      drn_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      drn_q   <= drn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q <= '0;
    end else if (ld_ins) begin
      ins_q <= instr;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign in_dec   = (state_q == ST_DEC);
  assign in_tap   = (state_q == ST_TAP);
  assign done     = (state_q == ST_DONE);
  assign tap_idx  = cnt_q;
  assign last_idx = ins_q.ord;
  assign ra_sel   = ins_q.ra;
  assign rb_sel   = ins_q.rb;
  assign fsym     = ins_q.fsym;
  assign csym     = ins_q.csym;
endmodule

// File: rtl/fts_data_walk.sv
module fts_data_walk #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] first_a,
  input  logic [AW-1:0] hi_a,
  input  logic [AW-1:0] lo_a,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] hi_q, lo_q;

  always_comb begin
    cur_d = cur_q;
    if (load)      cur_d = first_a;
    else if (step) cur_d = (cur_q == lo_q) ? hi_q : cur_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      cur_q <= cur_d;
      if (load) begin
        hi_q <= hi_a;
        lo_q <= lo_a;
      end
    end
  end

  assign addr = cur_q;
endmodule

// File: rtl/fts_coef_walk.sv
module fts_coef_walk
  import fts_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    base_a,
  input  logic             fold,
  input  logic [ORD_W-1:0] last_idx,
  input  logic [ORD_W-1:0] idx,
  output logic [AW-1:0]    addr,
  output logic             mirror
);
  logic [AW-1:0]    base_q;
  logic [ORD_W:0]   taps;
  logic [ORD_W:0]   half;
  logic [ORD_W-1:0] off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= base_a;
  end

  always_comb begin
    taps   = {1'b0, last_idx} + 1'b1;
    half   = (taps + 1'b1) >> 1;
    mirror = fold && ({1'b0, idx} >= half);
    off    = mirror ? (last_idx - idx) : idx;
    addr   = base_q + AW'(off);
  end
endmodule

// File: rtl/fir_tap_sequencer.sv
module fir_tap_sequencer
  import fts_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [OPC_W-1:0] OPC_FILTER = 6'h15,
  parameter int DRAIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       instr,
  output logic              busy,
  output logic [REG_W-1:0]  ra_sel,
  output logic [REG_W-1:0]  rb_sel,
  input  logic [2*AW-1:0]   ra_val,
  input  logic [2*AW-1:0]   rb_val,
  output logic              mac_clr,
  output logic              rd_en,
  output logic [AW-1:0]     dat_addr,
  output logic [AW-1:0]     cof_addr,
  output logic [ORD_W-1:0]  tap_idx,
  output logic              coef_mirror,
  output logic              dual_en,
  output logic              dual_neg,
  output logic              done
);
  logic             in_dec, in_tap;
  logic [ORD_W-1:0] last_idx;
  logic [1:0]       fsym;
  logic             csym;
  logic             mir_raw;

  fts_ctrl #(.OPC_FILTER(OPC_FILTER), .DRAIN_CYC(DRAIN_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(fts_instr_t'(instr)),
    .busy(busy), .in_dec(in_dec), .in_tap(in_tap), .done(done),
    .tap_idx(tap_idx), .last_idx(last_idx), .ra_sel(ra_sel), .rb_sel(rb_sel),
    .fsym(fsym), .csym(csym)
  );

  fts_data_walk #(.AW(AW)) u_data (
    .clk(clk), .rst_n(rst_n), .load(in_dec), .step(in_tap),
    .first_a(ra_val[2*AW-1:AW]), .hi_a(rb_val[2*AW-1:AW]), .lo_a(rb_val[AW-1:0]),
    .addr(dat_addr)
  );

  fts_coef_walk #(.AW(AW)) u_coef (
    .clk(clk), .rst_n(rst_n), .load(in_dec), .base_a(ra_val[AW-1:0]),
    .fold(csym), .last_idx(last_idx), .idx(tap_idx),
    .addr(cof_addr), .mirror(mir_raw)
  );

  assign mac_clr     = in_dec;
  assign rd_en       = in_tap;
  assign coef_mirror = in_tap & mir_raw;
  assign dual_en     = in_tap & (|fsym);
  assign dual_neg    = in_tap & fsym[1] & tap_idx[0];
endmodule

// File: rtl/fts_checker.sv
module fts_checker
  import fts_pkg::*;
#(
  parameter int AW = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             mac_clr,
  input logic             rd_en,
  input logic             done,
  input logic [ORD_W-1:0] tap_idx,
  input logic [AW-1:0]    dat_addr,
  input logic             coef_mirror
);
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mac_clr && !rd_en && !done));

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live && busy && !$past(busy) |-> $past(start));

  assert_clr_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    live && mac_clr |-> $past(start && !busy));

  assert_single_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mac_clr |=> !mac_clr);

  assert_first_tap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live && rd_en && $past(mac_clr) |-> tap_idx == '0);

  assert_tap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live && rd_en && $past(rd_en) |-> tap_idx == $past(tap_idx) + 1'b1);

  assert_addr_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    live && rd_en && $past(rd_en) |->
      (dat_addr == $past(dat_addr) - 1'b1) || (dat_addr >= $past(dat_addr)));

  assert_mirror_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live && rd_en && $past(rd_en) && $past(coef_mirror) |-> coef_mirror);

  assert_phase_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mac_clr, rd_en, done}));

  assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind fir_tap_sequencer fts_checker #(.AW(AW)) u_fts_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mac_clr(mac_clr),
  .rd_en(rd_en), .done(done), .tap_idx(tap_idx), .dat_addr(dat_addr),
  .coef_mirror(coef_mirror)
);

// File: tb/test_fir_tap_sequencer.sv
module test_fir_tap_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DRAIN = 4;

  logic        clk, rst_n, start;
  logic [23:0] instr;
  logic        busy, mac_clr, rd_en, coef_mirror, dual_en, dual_neg, done;
  logic [3:0]  ra_sel, rb_sel;
  logic [23:0] ra_val, rb_val;
  logic [11:0] dat_addr, cof_addr;
  logic [6:0]  tap_idx;

  logic [23:0] rf [16];
  assign ra_val = rf[ra_sel];
  assign rb_val = rf[rb_sel];

  fir_tap_sequencer i_fir_tap_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .busy(busy),
    .ra_sel(ra_sel), .rb_sel(rb_sel), .ra_val(ra_val), .rb_val(rb_val),
    .mac_clr(mac_clr), .rd_en(rd_en), .dat_addr(dat_addr), .cof_addr(cof_addr),
    .tap_idx(tap_idx), .coef_mirror(coef_mirror), .dual_en(dual_en),
    .dual_neg(dual_neg), .done(done)
  );

  typedef struct {
    bit busy, clr, rd, done, mir, den, dneg, fold;
    int da, ca, idx, ras, rbs;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  bit   running = 0;
  bit   last_busy = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] mk(input int opc, input int ra, input int rb,
                                      input int fs, input int cs, input int ord);
    return {6'(opc), 4'(ra), 4'(rb), 2'(fs), 1'(cs), 7'(ord)};
  endfunction

  always @(negedge clk) begin
    if (rst_n && running) begin
      exp_t e;
      e = '{default: 0};
      if (q.size() > 0) e = q.pop_front();
      last_busy = e.busy;
      chk("R10 busy", int'(busy), int'(e.busy));
      chk("R3 mac_clr", int'(mac_clr), int'(e.clr));
      chk("R5 rd_en", int'(rd_en), int'(e.rd));
      chk("R10 done", int'(done), int'(e.done));
      if (e.clr) begin
        chk("R3 ra_sel", int'(ra_sel), e.ras);
        chk("R3 rb_sel", int'(rb_sel), e.rbs);
      end
      if (e.rd) begin
        if (e.idx == 0) begin
          chk("R4 first data addr", int'(dat_addr), e.da);
          chk("R4 first coef addr", int'(cof_addr), e.ca);
        end
        chk("R6 dat_addr", int'(dat_addr), e.da);
        chk(e.fold ? "R8 cof_addr" : "R7 cof_addr", int'(cof_addr), e.ca);
        chk("R5 tap_idx", int'(tap_idx), e.idx);
        chk("R8 coef_mirror", int'(coef_mirror), int'(e.mir));
        chk("R9 dual_en", int'(dual_en), int'(e.den));
        chk("R9 dual_neg", int'(dual_neg), int'(e.dneg));
      end
    end
  end

  // Model: acceptance needs an idle cycle and the filter opcode (R2)
  task automatic issue(input logic [23:0] ins, input bit wait_first);
    if (wait_first) @(negedge clk);
    #1;
    start = 1'b1;
    instr = ins;
    if (!last_busy && ins[23:18] == 6'h15) begin
      exp_t e;
      int ra = ins[17:14], rb = ins[13:10];
      int fs = ins[9:8], cs = ins[7], ord = ins[6:0];
      int taps = ord + 1, half = (ord + 2) / 2;
      int d = rf[ra][23:12], cb = rf[ra][11:0];
      int hi = rf[rb][23:12], lo = rf[rb][11:0];
      e = '{default: 0};
      e.busy = 1; e.clr = 1; e.ras = ra; e.rbs = rb;
      q.push_back(e);
      for (int i = 0; i < taps; i++) begin
        e = '{default: 0};
        e.busy = 1; e.rd = 1; e.idx = i; e.da = d; e.fold = (cs != 0);
        e.mir = (cs != 0) && (i >= half);
        e.ca = (e.mir ? cb + (ord - i) : cb + i) & 12'hFFF;
        e.den = (fs != 0);
        e.dneg = ((fs & 2) != 0) && (i % 2 == 1);
        q.push_back(e);
        d = (d == lo) ? hi : ((d - 1) & 12'hFFF);
      end
      for (int i = 0; i < DRAIN; i++) begin
        e = '{default: 0};
        e.busy = 1;
        q.push_back(e);
      end
      e = '{default: 0};
      e.busy = 1; e.done = 1;
      q.push_back(e);
    end
    @(negedge clk);
    #1;
    start = 1'b0;
  endtask

  task automatic drain_q();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    instr = '0;
    for (int i = 0; i < 16; i++) rf[i] = 24'(i * 24'h010101);
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 rd_en in reset", int'(rd_en), 0);
    chk("R1 mac_clr in reset", int'(mac_clr), 0);
    chk("R1 done in reset", int'(done), 0);
    #1 rst_n = 1'b1;
    running = 1;
    repeat (3) @(negedge clk);

    // 75th order, folded coefficients, even dual, wrapping window
    rf[2] = {12'd10, 12'd100};
    rf[3] = {12'd20, 12'd5};
    issue(24'h548DCB, 1);
    drain_q();

    // R6: start at lower bound, unfolded, odd-negated dual (R7, R9)
    rf[4] = {12'd5, 12'd200};
    rf[5] = {12'd9, 12'd5};
    issue(mk(6'h15, 4, 5, 2, 0, 6), 1);
    drain_q();

    // R8: odd tap count fold
    issue(mk(6'h15, 2, 3, 2, 1, 4), 1);
    drain_q();

    // R8: single tap with fold, no mirror; single-address window
    rf[6] = {12'd7, 12'd4095};
    rf[7] = {12'd7, 12'd7};
    issue(mk(6'h15, 6, 7, 0, 1, 0), 1);
    drain_q();
    issue(mk(6'h15, 6, 7, 3, 0, 3), 1);
    drain_q();

    // R2: wrong opcode ignored
    issue(mk(6'h16, 2, 3, 1, 1, 5), 1);
    drain_q();

    // R2: start during taps ignored, then start in the done cycle ignored
    issue(mk(6'h15, 2, 3, 0, 0, 2), 1);
    repeat (2) @(negedge clk);
    issue(mk(6'h15, 4, 5, 1, 0, 3), 0);
    do @(negedge clk); while (!(q.size() == 0 && last_busy));
    issue(mk(6'h15, 4, 5, 1, 0, 3), 0);
    // back-to-back after idle: accepted
    issue(mk(6'h15, 4, 5, 1, 1, 9), 0);
    drain_q();

    // R5/R10: maximum order over the full address space
    rf[8] = {12'd3, 12'd4090};
    rf[9] = {12'd4095, 12'd0};
    issue(mk(6'h15, 8, 9, 1, 1, 127), 1);
    drain_q();
    issue(mk(6'h15, 8, 9, 0, 0, 127), 1);
    drain_q();

    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule